// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This unit owns the program counter of a simple 32-bit core and decides, once per enabled clock edge, where the counter moves next. Instructions are a fixed four bytes wide, so the default move is four bytes forward. A decoded flow-control code picks an alternative: a conditional branch that adds a word-scaled signed displacement to the following address, a region-local absolute jump, a jump that also hands back a return address, or an indirect jump to an address held in a register.

The branch decision comes in as a single equality bit from the operand comparator. The jump target keeps the four high bits of the following address and fills the rest from the 26-bit field followed by two zero bits. An indirect target that is not word aligned is refused. The counter stays where it is and a fault flag is shown while that request is present. The return address output always shows the address of the next sequential instruction, so a link write can take it in the same cycle as the jump.

There is no state machine. The only state is the counter register, and the flow code is an enumerated type decoded with a unique case.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc_out` reads 0x00000000 until the first enabled clock edge.
- R2: At a rising edge with `step_en` low, `pc_out` keeps its value whatever the other inputs are.
- R3: Flow code 0 (sequential): at an enabled edge, `pc_out` becomes `pc_out + 4`.
- R4: Flow code 1 (branch on equal): at an enabled edge, if `src_equal` is 1 then `pc_out` becomes `pc_out + 4 + (sign-extended br_offset × 4)`, otherwise `pc_out + 4`. For example, an offset of 3 lands 12 bytes past `pc_out + 4`.
- R5: Flow code 2 (branch on not equal): same target as R4, but it is taken when `src_equal` is 0 and not taken when `src_equal` is 1.
- R6: `br_offset` is signed two's complement. Bit 15 set moves the target backward, so an offset of 0xFFFF taken returns `pc_out` to its own value, and all additions wrap modulo 2^32.
- R7: Flow code 3 (jump): at an enabled edge, `pc_out` becomes `{(pc_out+4)[31:28], jmp_field, 2'b00}`.
- R8: Flow code 4 (jump and link): moves like R7. `link_addr` always equals `pc_out + 4` in the same cycle, with no register between them.
- R9: Flow code 5 (register jump): when `reg_target[1:0]` is 0, `pc_out` becomes `reg_target` at the enabled edge.
- R10: With flow code 5 and `reg_target[1:0]` not 0, `misalign_flag` is 1 in that same cycle and `pc_out` does not change at the edge. `misalign_flag` is 0 for every other input combination.
- R11: Flow codes 6 and 7 are not defined and behave as sequential (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Lets the counter advance at this edge |
| flow_kind | input | 3 | Flow code: 0 seq, 1 branch-eq, 2 branch-ne, 3 jump, 4 jump-link, 5 register jump |
| br_offset | input | 16 | Signed branch displacement in instructions |
| jmp_field | input | 26 | Absolute jump word index within the region |
| reg_target | input | 32 | Register value for the register jump |
| src_equal | input | 1 | 1 when the two compared operands match |
| pc_out | output | 32 | Current program counter |
| link_addr | output | 32 | Return address, always pc_out + 4 |
| misalign_flag | output | 1 | Refused unaligned register jump in this cycle |

## Verification
`link_addr` and `misalign_flag` depend only on the current counter and inputs. They are due in the same cycle as the stimulus, so the bench checks them a short delay after it drives the inputs on the falling edge, before the next rising edge. `pc_out` passes through one register and is due one rising edge after the stimulus. The bench checks it one time unit after that edge, against a model counter advanced by a bench function. Inputs only change on falling edges, so no sample falls on an active edge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5
    } flow_kind_t;
endpackage

// File: rtl/pcseq_target.sv
// Candidate addresses derived from the current counter and the instruction fields.
module pcseq_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [JF_W-1:0]  jfield,
    output logic [PC_W-1:0]  pc_plus4,
    output logic [PC_W-1:0]  br_target,
    output logic [PC_W-1:0]  jmp_target
);
    localparam int EXT_W = PC_W - OFF_W - 2;
    localparam int HI_W  = PC_W - JF_W - 2;

    logic [PC_W-1:0] disp;

    always_comb begin
        pc_plus4   = pc + PC_W'(4);
        disp       = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        br_target  = pc_plus4 + disp;
        jmp_target = {pc_plus4[PC_W-1 -: HI_W], jfield, 2'b00};
    end
endmodule

// File: rtl/pcseq_select.sv
// Chooses the next counter value from the flow code.
module pcseq_select
    import pcseq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [2:0]      kind,
    input  logic            eq,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] pc_plus4,
    input  logic [PC_W-1:0] br_target,
    input  logic [PC_W-1:0] jmp_target,
    input  logic [PC_W-1:0] reg_target,
    output logic [PC_W-1:0] next_pc,
    output logic            misalign
);
    flow_kind_t k;

    always_comb begin
        k        = flow_kind_t'(kind);
        misalign = 1'b0;
        next_pc  = pc_plus4;
        unique case (k)
            FLOW_SEQ:  next_pc = pc_plus4;
            FLOW_BEQ:  next_pc = eq ? br_target : pc_plus4;
            FLOW_BNE:  next_pc = eq ? pc_plus4 : br_target;
            FLOW_JMP,
            FLOW_JAL:  next_pc = jmp_target;
            FLOW_JREG: begin
                if (reg_target[1:0] != 2'b00) begin
                    misalign = 1'b1;
                    next_pc  = pc;
                end else begin
                    next_pc  = reg_target;
                end
            end
            default:   next_pc = pc_plus4;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter int              OFF_W     = 16,
    parameter int              JF_W      = 26,
    parameter logic [PC_W-1:0] RESET_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [2:0]       flow_kind,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [JF_W-1:0]  jmp_field,
    input  logic [PC_W-1:0]  reg_target,
    input  logic             src_equal,
    output logic [PC_W-1:0]  pc_out,
    output logic [PC_W-1:0]  link_addr,
    output logic             misalign_flag
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_plus4, br_target, jmp_target, next_pc;
    logic            misalign;

    pcseq_target #(.PC_W(PC_W), .OFF_W(OFF_W), .JF_W(JF_W)) u_target (
        .pc(pc_q), .offset(br_offset), .jfield(jmp_field),
        .pc_plus4(pc_plus4), .br_target(br_target), .jmp_target(jmp_target)
    );

    pcseq_select #(.PC_W(PC_W)) u_select (
        .kind(flow_kind), .eq(src_equal), .pc(pc_q), .pc_plus4(pc_plus4),
        .br_target(br_target), .jmp_target(jmp_target), .reg_target(reg_target),
        .next_pc(next_pc), .misalign(misalign)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pc_q <= RESET_VEC;
        else if (step_en) pc_q <= next_pc;
    end

    always_comb begin
        pc_out        = pc_q;
        link_addr     = pc_plus4;
        misalign_flag = misalign;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc_q));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && flow_kind == 3'd0) |=> (pc_q == $past(pc_q) + PC_W'(4)));

    assert_jreg_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && flow_kind == 3'd5 && reg_target[1:0] == 2'b00) |=> (pc_q == $past(reg_target)));

    assert_misalign_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && misalign_flag) |=> $stable(pc_q));

    assert_flag_only_jreg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_flag |-> (flow_kind == 3'd5));

    assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [2:0]  flow_kind = '0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] reg_target = '0;
    logic        src_equal = 1'b0;
    logic [31:0] pc_out, link_addr;
    logic        misalign_flag;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_pc = 32'h0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .flow_kind(flow_kind),
        .br_offset(br_offset), .jmp_field(jmp_field), .reg_target(reg_target),
        .src_equal(src_equal), .pc_out(pc_out), .link_addr(link_addr),
        .misalign_flag(misalign_flag)
    );

    function automatic logic [31:0] model_next(input logic [31:0] pc, input logic [2:0] k,
            input logic [15:0] off, input logic [25:0] jf, input logic [31:0] r, input logic eq);
        logic [31:0] seq, br;
        seq = pc + 32'd4;
        br  = seq + ({{16{off[15]}}, off} <<< 2);
        case (k)
            3'd1: return eq ? br : seq;
            3'd2: return eq ? seq : br;
            3'd3, 3'd4: return {seq[31:28], jf, 2'b00};
            3'd5: return (r[1:0] != 2'b00) ? pc : r;
            default: return seq;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] k, input logic en);
        if (!en) return "R2";
        case (k)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational outputs, then the counter after the rising edge.
    task automatic step(input logic en, input logic [2:0] k, input logic [15:0] off,
                        input logic [25:0] jf, input logic [31:0] r, input logic eq, input string tag);
        logic exp_flag;
        @(negedge clk);
        step_en = en; flow_kind = k; br_offset = off; jmp_field = jf;
        reg_target = r; src_equal = eq;
        #1;
        check32("R8", link_addr, model_pc + 32'd4);
        exp_flag = (k == 3'd5) && (r[1:0] != 2'b00);
        check32("R10", {31'd0, misalign_flag}, {31'd0, exp_flag});
        if (en) model_pc = model_next(model_pc, k, off, jf, r, eq);
        @(posedge clk);
        #1;
        check32((tag == "") ? req_of(k, en) : tag, pc_out, model_pc);
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check32("R1", pc_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check32("R1", pc_out, 32'h0);

        // R2: disabled step with a jump request
        step(1'b0, 3'd3, 16'h0, 26'h3FFFFFF, 32'h0, 1'b0, "R2");
        // R3 sequential
        step(1'b1, 3'd0, 16'h0, 26'h0, 32'h0, 1'b0, "R3");
        // R4: offset 3 taken, +12 past pc+4
        step(1'b1, 3'd1, 16'd3, 26'h0, 32'h0, 1'b1, "R4");
        check32("R4", pc_out, 32'h0000_0014);
        step(1'b1, 3'd1, 16'd3, 26'h0, 32'h0, 1'b0, "R4");
        // R5 both polarities
        step(1'b1, 3'd2, 16'd5, 26'h0, 32'h0, 1'b0, "R5");
        step(1'b1, 3'd2, 16'd5, 26'h0, 32'h0, 1'b1, "R5");
        // R6 offset -1 returns to self, then a larger backward step
        step(1'b1, 3'd1, 16'hFFFF, 26'h0, 32'h0, 1'b1, "R6");
        step(1'b1, 3'd2, 16'hFFF0, 26'h0, 32'h0, 1'b0, "R6");
        // R9 aligned register jump into a high region, then R7 keeps region bits
        step(1'b1, 3'd5, 16'h0, 26'h0, 32'hA000_0100, 1'b0, "R9");
        check32("R9", pc_out, 32'hA000_0100);
        step(1'b1, 3'd3, 16'h0, 26'h0000040, 32'h0, 1'b0, "R7");
        check32("R7", pc_out, 32'hA000_0100);
        // R8 jump and link
        step(1'b1, 3'd4, 16'h0, 26'h0001000, 32'h0, 1'b0, "R8");
        // R10 misaligned register jump holds the counter
        step(1'b1, 3'd5, 16'h0, 26'h0, 32'h0000_2002, 1'b0, "R10");
        step(1'b1, 3'd5, 16'h0, 26'h0, 32'h0000_2001, 1'b0, "R10");
        // R11 undefined codes
        step(1'b1, 3'd6, 16'h7, 26'h5, 32'h3, 1'b1, "R11");
        step(1'b1, 3'd7, 16'h7, 26'h5, 32'h3, 1'b1, "R11");
        // R6 wraparound near the top of the address space
        step(1'b1, 3'd5, 16'h0, 26'h0, 32'hFFFF_FFFC, 1'b0, "R9");
        step(1'b1, 3'd0, 16'h0, 26'h0, 32'h0, 1'b0, "R6");
        check32("R6", pc_out, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (($urandom() % 4) != 0) r[1:0] = 2'b00;
            step(($urandom() % 8) != 0, 3'($urandom()), 16'($urandom()),
                 26'($urandom()), r, 1'($urandom()), "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule